// File: doc/BRIEF.md
# Eight-Lane Word Serializer with Forwarded Bit and Frame Clocks

This block turns parallel converter samples into serial streams. Eight channels each present a 12-bit word, and all eight words are captured on the same tick of a fast clock that runs at twelve times the sample rate. Each captured word then leaves on its own one-bit lane, one bit per fast tick. A whole word therefore takes exactly one frame period, and the next capture happens on the tick after the last bit.

Two clocks are forwarded with the data. The bit clock runs at six times the frame rate, so each of its edges carries one data bit. The frame clock runs at the sample rate and rises together with the first bit of every word. Both come from the same tick counter and the same register stage as the lane outputs, so they cannot drift against the data. A receiver uses the frame clock to find word boundaries and the bit clock to sample the bits.

Word order on the lanes is either least-significant bit first (the default, `msb_first` low) or most-significant bit first. The order is sampled at capture time.

The sequencing is a two-state machine with a slot counter:
- State `ST_HIGH` covers slots 0 to 5, the half of the frame in which the frame clock is high.
- State `ST_LOW` covers slots 6 to 11.
- Transition `T_HALF` goes from `ST_HIGH` to `ST_LOW` after slot 5.
- Transition `T_WRAP` goes from `ST_LOW` back to `ST_HIGH` after slot 11 and clears the slot counter.
- Reset places the machine in `ST_HIGH` at slot 0.

Top module: `ser8_lane_top`

## Requirements
- R1: Each lane sends its captured 12-bit word as 12 consecutive bits, one bit per fast-clock tick. The first bit appears on the lane output right after the capture edge, and bit k of the order appears after the k-th following edge.
- R2: A capture happens on the first rising edge after reset is released and then on every 12th edge. Values on `samp_word` at any other edge have no effect on the bits being sent.
- R3: The bit clock output `bclk_out` inverts on every fast tick. It is 0 in reset and 1 after the first tick that follows reset.
- R4: The frame clock output `fclk_out` goes high with the first bit of each word, stays high for 6 ticks and is then low for 6 ticks.
- R5: With `msb_first` = 0 at capture, bit 0 of the word is sent first and bit 11 is sent last.
- R6: With `msb_first` = 1 at capture, bit 11 is sent first and bit 0 is sent last. A change of `msb_first` between captures has no effect on the word in flight.
- R7: Lane i takes its word from `samp_word[12*i+11 : 12*i]`. All eight lanes capture on the same edge and send their first bits on the same tick.
- R8: A synchronous reset drives every lane, `bclk_out` and `fclk_out` to 0 and restarts the frame at slot 0. This holds even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serializing clock, twelve ticks per sample |
| rst | input | 1 | Synchronous reset, active high |
| msb_first | input | 1 | Bit order: 0 sends the LSB first, 1 sends the MSB first; sampled at capture |
| samp_word | input | 96 | Eight 12-bit channel words; lane i uses bits 12*i+11 to 12*i |
| lane_out | output | 8 | One serial data bit per lane |
| bclk_out | output | 1 | Forwarded bit clock, six times the frame rate |
| fclk_out | output | 1 | Forwarded frame clock, high during the first six bits of each word |

## Verification
Some properties can be checked on every cycle, and assertions do that:
- the slot counter never leaves its 12-position range;
- a capture is never followed directly by another capture;
- the bit clock inverts on every tick;
- the frame clock is high right after each capture;
- the lanes and the forwarded clocks are zero after a reset tick.

Other behaviour can only be shown by the directed scenarios in the bench, because it depends on the stimulus:
- the actual bit sequence on each lane in both bit orders;
- the mapping of each channel slice to its lane;
- that changes to the words and to the order during a frame are ignored;
- that a reset in the middle of a word restarts the frame cleanly.

// File: rtl/ser8_pkg.sv
package ser8_pkg;

    // Frame sequencing states: first half (frame clock high), second half (low)
    typedef enum logic [0:0] {
        ST_HIGH = 1'b0,
        ST_LOW  = 1'b1
    } frame_state_e;

endpackage

// File: rtl/ser8_frame_ctrl.sv
module ser8_frame_ctrl
    import ser8_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst,
    output logic load_o,
    output logic fclk_o,
    output logic bclk_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int HALF  = WORD_W / 2;
    localparam logic [CNT_W-1:0] SLOT_FIRST    = '0;
    localparam logic [CNT_W-1:0] SLOT_HALF_END = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST     = CNT_W'(WORD_W - 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] slot_q, slot_d;

    // State and slot register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HIGH;
            slot_q  <= SLOT_FIRST;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next-state logic: T_HALF and T_WRAP
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q + CNT_W'(1);
        unique case (state_q)
            ST_HIGH: begin
                if (slot_q == SLOT_HALF_END) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (slot_q == SLOT_LAST) begin
                    state_d = ST_HIGH;
                    slot_d  = SLOT_FIRST;
                end
            end
            default: begin
                state_d = ST_HIGH;
                slot_d  = SLOT_FIRST;
            end
        endcase
    end

    // Capture strobe on slot 0 of the high half
    assign load_o = (state_q == ST_HIGH) && (slot_q == SLOT_FIRST);

    // Forwarded clocks, registered in the same stage as the lane bits
    always_ff @(posedge clk) begin
        if (rst) begin
            fclk_o <= 1'b0;
            bclk_o <= 1'b0;
        end else begin
            fclk_o <= (state_q == ST_HIGH);
            bclk_o <= ~bclk_o;
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_q <= SLOT_LAST); // R2

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o); // R2

    AST_BCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bclk_o != $past(bclk_o))); // R3

    AST_LOAD_FCLK: assert property (@(posedge clk) disable iff (rst)
        load_o |=> fclk_o); // R4

endmodule

// File: rtl/ser8_lane.sv
module ser8_lane #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              msb_first_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);

    logic [WORD_W-1:0] rev_word;
    logic [WORD_W-1:0] ordered;
    logic [WORD_W-2:0] rest_q;

    // The order is fixed once at capture: the word is stored so that
    // it always leaves from bit 0
    always_comb begin
        for (int b = 0; b < WORD_W; b++) begin
            rev_word[b] = word_i[WORD_W-1-b];
        end
        ordered = msb_first_i ? rev_word : word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_o  <= 1'b0;
            rest_q <= '0;
        end else if (load_i) begin
            bit_o  <= ordered[0];
            rest_q <= ordered[WORD_W-1:1];
        end else begin
            bit_o  <= rest_q[0];
            rest_q <= rest_q >> 1;
        end
    end

endmodule

// File: rtl/ser8_lane_top.sv
module ser8_lane_top #(
    parameter int NUM_LANES = 8,
    parameter int WORD_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          msb_first,
    input  logic [NUM_LANES*WORD_W-1:0]   samp_word,
    output logic [NUM_LANES-1:0]          lane_out,
    output logic                          bclk_out,
    output logic                          fclk_out
);

    logic load;

    ser8_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .load_o (load),
        .fclk_o (fclk_out),
        .bclk_o (bclk_out)
    );

    // One shift lane per channel, all sharing the capture strobe
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        ser8_lane #(.WORD_W(WORD_W)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .load_i      (load),
            .msb_first_i (msb_first),
            .word_i      (samp_word[g*WORD_W +: WORD_W]),
            .bit_o       (lane_out[g])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (lane_out == '0 && !bclk_out && !fclk_out)); // R8

endmodule

// File: tb/sim_ser8_lane_top.sv
`timescale 1ns/1ps
module sim_ser8_lane_top;

    localparam int NL = 8;
    localparam int WW = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              msb_first = 1'b0;
    logic [NL*WW-1:0]  samp_word = '0;
    logic [NL-1:0]     lane_out;
    logic              bclk_out;
    logic              fclk_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic bclk_exp = 1'b0;

    always #2.5 clk = ~clk;

    ser8_lane_top u0 (
        .clk       (clk),
        .rst       (rst),
        .msb_first (msb_first),
        .samp_word (samp_word),
        .lane_out  (lane_out),
        .bclk_out  (bclk_out),
        .fclk_out  (fclk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NL*WW-1:0] make_words(input int seed);
        logic [NL*WW-1:0] w;
        for (int i = 0; i < NL; i++) begin
            w[i*WW +: WW] = WW'((seed * 613 + i * 347 + (seed ^ i) * 29) & 12'hFFF);
        end
        return w;
    endfunction

    // Sends one frame starting at the current negedge (the next posedge is a
    // capture). With disturb set, words and order change after the first bit.
    task automatic play_frame(input logic [NL*WW-1:0] w, input logic msb,
                              input logic disturb, input string req);
        samp_word = w;
        msb_first = msb;
        for (int k = 0; k < WW; k++) begin
            logic [NL-1:0] exp_lanes;
            @(posedge clk);
            @(negedge clk);
            bclk_exp = ~bclk_exp;
            for (int i = 0; i < NL; i++) begin
                exp_lanes[i] = msb ? w[i*WW + WW-1-k] : w[i*WW + k];
            end
            check({req, " lanes"}, 32'(lane_out), 32'(exp_lanes));
            check("R4 frame clock", 32'(fclk_out), 32'(k < WW/2));
            check("R3 bit clock", 32'(bclk_out), 32'(bclk_exp));
            if (disturb && k == 0) begin
                samp_word = ~w;
                msb_first = ~msb;
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 reset lanes", 32'(lane_out), 32'h0);
        check("R8 reset fclk", 32'(fclk_out), 32'h0);
        check("R8 reset bclk", 32'(bclk_out), 32'h0);
        bclk_exp = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_lsb_first();
        play_frame(make_words(1), 1'b0, 1'b0, "R5 R1 R7 lsb");
        play_frame(96'h123456789ABCDEF012345678, 1'b0, 1'b0, "R5 R7 lsb pattern");
    endtask

    task automatic t_msb_first();
        play_frame(make_words(2), 1'b1, 1'b0, "R6 R1 msb");
        play_frame({NL{12'h801}}, 1'b1, 1'b0, "R6 edges");
    endtask

    task automatic t_ignore_midframe();
        play_frame(make_words(3), 1'b0, 1'b1, "R2 R6 ignore");
        play_frame(make_words(4), 1'b1, 1'b1, "R2 R6 ignore msb");
    endtask

    task automatic t_lane_map();
        logic [NL*WW-1:0] w;
        // Each lane carries its own index in the low bits: shows the slice mapping
        for (int i = 0; i < NL; i++) w[i*WW +: WW] = WW'(12'hA00 | i);
        play_frame(w, 1'b0, 1'b0, "R7 lane map");
    endtask

    task automatic t_midframe_reset();
        samp_word = make_words(5);
        msb_first = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        t_reset();
        play_frame(make_words(6), 1'b0, 1'b0, "R8 R2 restart");
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_lsb_first();
        t_msb_first();
        t_ignore_midframe();
        t_lane_map();
        t_midframe_reset();
        play_frame(make_words(7), 1'b1, 1'b0, "R1 back to back");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule